// File: doc/BRIEF.md
# Request Descriptor to Transaction-Layer Header Formatter

This block sits on the transmit side of a PCIe endpoint. It receives each outgoing request as an AXI4-Stream packet that opens with a fixed 128-bit request descriptor. Payload beats may follow the descriptor. The block collects the descriptor and converts it into a transaction-layer request header. It sends that header on its output stream and then forwards the payload beats untouched. Memory, I/O and message requests are handled. The tag for a non-posted request is taken from the descriptor or from an internal 8-bit counter. The No Snoop, Relaxed Ordering and ID-Based Ordering attribute bits are cleared unless their enable inputs are set.

The data path width `DATA_W` is either 64 or 128. The descriptor therefore spans `NB = 128/DATA_W` input beats, with the lower bits in the earlier beat. The header always occupies 128 bits, sent over the same number of output beats. A 3-dword header has its fourth dword zeroed, and the format field says which length applies. The control path is a three-state machine:

- **DESC**: the input is ready and descriptor beats are collected.
- **HDR**: the input is held off and the header beats are sent.
- **PAY**: input and output are joined combinationally.

The transitions are:

- DESC→HDR when the final descriptor beat is accepted.
- HDR→DESC when the final header beat is taken and the packet has ended.
- HDR→PAY when the final header beat is taken and payload follows.
- PAY→DESC when a payload beat with tlast is taken.

Request type codes (descriptor bits 78:75):

| Code | Request |
|------|---------|
| 0 | memory read |
| 1 | memory write |
| 2 | I/O read |
| 3 | I/O write |
| 12 | message without data |
| 13 | message with data |

Any other code is formatted as a memory read.

Top module: `req_hdr_fmt`

## Requirements
- R1: While reset is held and in the cycle after its release, `s_tready` is 1 and `m_tvalid` is 0.
- R2: The descriptor is assembled from NB input beats, the lower 64 bits first when DATA_W=64. The header leaves as NB beats, with dword 0 in bits 31:0 of the first beat and dword 1 in bits 63:32. For a packet whose descriptor beat carries tlast, `m_tlast` is set on the last header beat.
- R3: While a header beat is presented on the output, `s_tready` is 0.
- R4: Payload beats appear on the output unchanged, in order, with their tlast. The beat after the one carrying tlast is the next packet's descriptor.
- R5: When `m_tready` is low, a presented header beat holds its data. In the payload phase, `s_tready` follows `m_tready`. No beat is lost or duplicated.
- R6: Dword 0 bits 31:29 are {0, D, F}. D is 1 for codes 1, 3 and 13. F is 1 for a 4-dword header. Type bits 28:24 are 00000 for memory, 00010 for I/O and {10, routing} for messages.
- R7: A memory request with nonzero descriptor bits 63:32 gets a 4-dword header: dword 2 holds bits 63:32, and dword 3 holds bits 31:2 with 00 below them. Otherwise dword 2 holds bits 31:2 with 00 below them, and dword 3 is 0.
- R8: An I/O request always gets a 3-dword header, laid out as the 3-dword memory case, whatever descriptor bits 63:32 hold.
- R9: A posted request (codes 1, 12, 13) puts descriptor bits 103:96 into dword 1 bits 15:8.
- R10: A non-posted request uses descriptor bits 103:96 as its tag when `cfg_client_tag` is 1. Otherwise it uses an internal 8-bit counter that starts at 0 after reset, advances by one per such request, and wraps from 255 to 0.
- R11: Dword 0 bit 12 is descriptor bit 124 AND `cfg_attr_en[0]`. Bit 13 is bit 125 AND `cfg_attr_en[1]`. Bit 18 is bit 126 AND `cfg_attr_en[2]`.
- R12: A message always gets a 4-dword header. Routing bits 114:112 go to type bits 26:24, and message code bits 111:104 go to dword 1 bits 7:0. Dword 2 is descriptor bits 31:0 and dword 3 is bits 63:32.
- R13: The common fields of dwords 0 and 1 are filled as follows:
  - Dword 0 bits 9:0 are the dword count bits 73:64. The count is not checked against the payload.
  - Bit 14 is the poison bit 79.
  - Bits 22:20 are the traffic class 123:121.
  - Bits 11:10 are the address type 1:0 for memory requests and 0 otherwise.
  - Dword 1 bits 31:16 are descriptor bits 95:80.
  - For non-messages, dword 1 bits 7:0 are 0x0F when the count is at most 1 and 0xFF otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_client_tag | input | 1 | Non-posted requests keep the descriptor tag |
| cfg_attr_en | input | 3 | Enables for No Snoop (0), Relaxed Ordering (1), ID-Based Ordering (2) |
| s_tdata | input | DATA_W | Request stream data |
| s_tvalid | input | 1 | Request stream valid |
| s_tready | output | 1 | Request stream ready |
| s_tlast | input | 1 | Request stream end of packet |
| m_tdata | output | DATA_W | Header and payload stream data |
| m_tvalid | output | 1 | Output valid |
| m_tready | input | 1 | Output ready |
| m_tlast | output | 1 | Output end of packet |

## Verification
The bench builds the block with DATA_W=64. That width brings the two-beat descriptor assembly and the split of the header across two output beats within reach, including a header held over stalls between its halves. With this width, header-only packets put tlast on the second header beat, and input gaps can fall between the two descriptor beats. A run of more than 256 generator-tagged reads carries the tag counter through its wrap from 255 to 0.

// File: rtl/rhf_pkg.sv
package rhf_pkg;

    typedef enum logic [1:0] {
        ST_DESC,
        ST_HDR,
        ST_PAY
    } rhf_state_e;

    localparam logic [3:0] RT_MRD  = 4'd0;
    localparam logic [3:0] RT_MWR  = 4'd1;
    localparam logic [3:0] RT_IORD = 4'd2;
    localparam logic [3:0] RT_IOWR = 4'd3;
    localparam logic [3:0] RT_MSG  = 4'd12;
    localparam logic [3:0] RT_MSGD = 4'd13;

    // Descriptor layout, most significant field first (128 bits).
    typedef struct packed {
        logic        rsvd;
        logic [2:0]  attr;
        logic [2:0]  tc;
        logic        rid_en;
        logic [15:0] cpl_id;
        logic [7:0]  tag;
        logic [7:0]  bus;
        logic [7:0]  devfn;
        logic        poison;
        logic [3:0]  rtype;
        logic [10:0] dw_cnt;
        logic [61:0] addr;
        logic [1:0]  at;
    } rhf_desc_t;

    function automatic logic is_posted(input logic [3:0] t);
        return (t == RT_MWR) || (t == RT_MSG) || (t == RT_MSGD);
    endfunction

endpackage

// File: rtl/rhf_desc_capture.sv
module rhf_desc_capture #(
    parameter int DATA_W = 64,
    parameter int NB     = 128 / DATA_W,
    parameter int BW     = (NB > 1) ? $clog2(NB) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [BW-1:0]     idx,
    input  logic [DATA_W-1:0] data,
    output logic [127:0]      desc_full
);

    generate
        if (NB == 1) begin : g_one_beat
            assign desc_full = data;
        end else begin : g_multi_beat
            logic [(NB-1)*DATA_W-1:0] low_q;

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    low_q <= '0;
                end else if (take && (idx != BW'(NB - 1))) begin
                    low_q[int'(idx)*DATA_W +: DATA_W] <= data;
                end
            end

            assign desc_full = {data, low_q};
        end
    endgenerate

endmodule

// File: rtl/rhf_tag_gen.sv
module rhf_tag_gen #(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    output logic [TAG_W-1:0] cur
);

    logic [TAG_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (take) begin
            cnt_q <= cnt_q + TAG_W'(1);
        end
    end

    assign cur = cnt_q;

endmodule

// File: rtl/rhf_hdr_build.sv
module rhf_hdr_build
    import rhf_pkg::*;
(
    input  rhf_desc_t    desc,
    input  logic [7:0]   tag,
    input  logic [2:0]   attr_en,
    output logic [127:0] hdr
);

    logic        is_msg, is_io, has_data, four_dw;
    logic [4:0]  typ;
    logic [31:0] dw0, dw1, dw2, dw3, lo_addr, hi_addr;
    logic        unused_bits;

    assign unused_bits = ^{desc.rsvd, desc.rid_en, desc.cpl_id[15:11], desc.dw_cnt[10]};

    always_comb begin
        is_io    = (desc.rtype == RT_IORD) || (desc.rtype == RT_IOWR);
        is_msg   = (desc.rtype == RT_MSG) || (desc.rtype == RT_MSGD);
        has_data = (desc.rtype == RT_MWR) || (desc.rtype == RT_IOWR) || (desc.rtype == RT_MSGD);
        hi_addr  = desc.addr[61:30];
        lo_addr  = {desc.addr[29:0], 2'b00};
        four_dw  = is_msg || (!is_io && (hi_addr != 32'd0));

        if (is_msg)     typ = {2'b10, desc.cpl_id[10:8]};
        else if (is_io) typ = 5'b00010;
        else            typ = 5'b00000;

        dw0        = '0;
        dw0[31:29] = {1'b0, has_data, four_dw};
        dw0[28:24] = typ;
        dw0[22:20] = desc.tc;
        dw0[18]    = desc.attr[2] & attr_en[2];
        dw0[14]    = desc.poison;
        dw0[13]    = desc.attr[1] & attr_en[1];
        dw0[12]    = desc.attr[0] & attr_en[0];
        dw0[11:10] = (is_io || is_msg) ? 2'b00 : desc.at;
        dw0[9:0]   = desc.dw_cnt[9:0];

        dw1[31:16] = {desc.bus, desc.devfn};
        dw1[15:8]  = tag;
        if (is_msg) dw1[7:0] = desc.cpl_id[7:0];
        else        dw1[7:0] = {(desc.dw_cnt > 11'd1) ? 4'hF : 4'h0, 4'hF};

        if (is_msg) begin
            dw2 = {desc.addr[29:0], desc.at};
            dw3 = hi_addr;
        end else if (four_dw) begin
            dw2 = hi_addr;
            dw3 = lo_addr;
        end else begin
            dw2 = lo_addr;
            dw3 = '0;
        end

        hdr = {dw3, dw2, dw1, dw0};
    end

endmodule

// File: rtl/req_hdr_fmt.sv
module req_hdr_fmt
    import rhf_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_client_tag,
    input  logic [2:0]        cfg_attr_en,
    input  logic [DATA_W-1:0] s_tdata,
    input  logic              s_tvalid,
    output logic              s_tready,
    input  logic              s_tlast,
    output logic [DATA_W-1:0] m_tdata,
    output logic              m_tvalid,
    input  logic              m_tready,
    output logic              m_tlast
);

    localparam int NB = 128 / DATA_W;
    localparam int BW = (NB > 1) ? $clog2(NB) : 1;
    localparam logic [BW-1:0] LAST_BEAT = BW'(NB - 1);

    rhf_state_e    state_q;
    logic [BW-1:0] beat_q;
    logic          end_q;
    rhf_desc_t     desc_q;
    rhf_desc_t     desc_in;
    logic [7:0]    tag_q;
    logic [127:0]  desc_full;
    logic [127:0]  hdr;
    logic [7:0]    gen_tag;
    logic          gen_take;
    logic          use_gen;
    logic          in_desc, in_hdr, hdr_first;
    logic          desc_take, desc_done;

    assign in_desc   = (state_q == ST_DESC);
    assign in_hdr    = (state_q == ST_HDR);
    assign hdr_first = (beat_q == '0);
    assign desc_take = in_desc && s_tvalid;
    assign desc_done = desc_take && (beat_q == LAST_BEAT);
    assign desc_in   = rhf_desc_t'(desc_full);
    assign use_gen   = !is_posted(desc_in.rtype) && !cfg_client_tag;
    assign gen_take  = desc_done && use_gen;

    rhf_desc_capture #(.DATA_W(DATA_W), .NB(NB), .BW(BW)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .take      (desc_take),
        .idx       (beat_q),
        .data      (s_tdata),
        .desc_full (desc_full)
    );

    rhf_tag_gen #(.TAG_W(8)) u_tag (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (gen_take),
        .cur   (gen_tag)
    );

    rhf_hdr_build u_hdr (
        .desc    (desc_q),
        .tag     (tag_q),
        .attr_en (cfg_attr_en),
        .hdr     (hdr)
    );

    // State register and sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DESC;
            beat_q  <= '0;
            end_q   <= 1'b0;
            desc_q  <= '0;
            tag_q   <= '0;
        end else begin
            unique case (state_q)
                ST_DESC: begin
                    if (desc_done) begin
                        state_q <= ST_HDR;
                        beat_q  <= '0;
                        end_q   <= s_tlast;
                        desc_q  <= desc_in;
                        tag_q   <= use_gen ? gen_tag : desc_in.tag;
                    end else if (desc_take) begin
                        beat_q  <= beat_q + BW'(1);
                    end
                end
                ST_HDR: begin
                    if (m_tready) begin
                        if (beat_q == LAST_BEAT) begin
                            beat_q  <= '0;
                            state_q <= end_q ? ST_DESC : ST_PAY;
                        end else begin
                            beat_q  <= beat_q + BW'(1);
                        end
                    end
                end
                ST_PAY: begin
                    if (s_tvalid && m_tready && s_tlast) begin
                        state_q <= ST_DESC;
                    end
                end
                default: state_q <= ST_DESC;
            endcase
        end
    end

    // Output decode.
    always_comb begin
        s_tready = 1'b0;
        m_tvalid = 1'b0;
        m_tdata  = '0;
        m_tlast  = 1'b0;
        unique case (state_q)
            ST_DESC: begin
                s_tready = 1'b1;
            end
            ST_HDR: begin
                m_tvalid = 1'b1;
                m_tdata  = hdr[int'(beat_q)*DATA_W +: DATA_W];
                m_tlast  = end_q && (beat_q == LAST_BEAT);
            end
            ST_PAY: begin
                s_tready = m_tready;
                m_tvalid = s_tvalid;
                m_tdata  = s_tdata;
                m_tlast  = s_tlast;
            end
            default: begin
                s_tready = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/req_hdr_fmt_chk.sv
module rhf_chk #(
    parameter int DATA_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_hdr,
    input logic              hdr_first,
    input logic              s_tready,
    input logic              m_tvalid,
    input logic              m_tready,
    input logic [DATA_W-1:0] m_tdata,
    input logic [2:0]        cfg_attr_en,
    input logic [3:0]        req_type,
    input logic              gen_take,
    input logic [7:0]        gen_tag
);

    // R3
    hdr_blocks_input_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_hdr |-> !s_tready);

    // R5
    hdr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hdr && !m_tready) |=> (m_tvalid && $stable(m_tdata)));

    // R11
    ns_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hdr && hdr_first && !cfg_attr_en[0]) |-> !m_tdata[12]);

    // R10
    tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        gen_take |=> (gen_tag == $past(gen_tag) + 8'd1));

    // R10
    tag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_take |=> $stable(gen_tag));

    // R8
    io_short_hdr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_hdr && hdr_first && (req_type == 4'd2 || req_type == 4'd3)) |-> !m_tdata[29]);

endmodule

bind req_hdr_fmt rhf_chk #(.DATA_W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_hdr      (in_hdr),
    .hdr_first   (hdr_first),
    .s_tready    (s_tready),
    .m_tvalid    (m_tvalid),
    .m_tready    (m_tready),
    .m_tdata     (m_tdata),
    .cfg_attr_en (cfg_attr_en),
    .req_type    (desc_q.rtype),
    .gen_take    (gen_take),
    .gen_tag     (gen_tag)
);

// File: tb/tb_req_hdr_fmt.sv
module tb_req_hdr_fmt;

    localparam int CLK_P = 10;
    localparam int DW    = 64;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_client_tag = 1'b0;
    logic [2:0]    cfg_attr_en = 3'b111;
    logic [DW-1:0] s_tdata = '0;
    logic          s_tvalid = 1'b0;
    logic          s_tready;
    logic          s_tlast = 1'b0;
    logic [DW-1:0] m_tdata;
    logic          m_tvalid;
    logic          m_tready = 1'b1;
    logic          m_tlast;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    int pkt_id = 0;
    bit stall_mode = 0;
    bit gap_mode   = 0;
    logic [7:0] gen_model = 8'd0;

    logic [DW:0] exp_q[$];
    bit          hdr_q[$];
    string       lbl_q[$];

    always #(CLK_P/2) clk = ~clk;

    req_hdr_fmt #(.DATA_W(DW)) dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_client_tag (cfg_client_tag),
        .cfg_attr_en    (cfg_attr_en),
        .s_tdata        (s_tdata),
        .s_tvalid       (s_tvalid),
        .s_tready       (s_tready),
        .s_tlast        (s_tlast),
        .m_tdata        (m_tdata),
        .m_tvalid       (m_tvalid),
        .m_tready       (m_tready),
        .m_tlast        (m_tlast)
    );

    function automatic logic [127:0] mk_desc(input int ty, input logic [63:0] addr, input logic [1:0] at,
                                             input logic [10:0] cnt, input logic [7:0] tag,
                                             input logic [15:0] cid, input logic [2:0] tc,
                                             input logic [2:0] attr, input bit poison,
                                             input logic [15:0] rid);
        logic [127:0] d;
        d = '0;
        d[63:2]    = addr[63:2];
        d[1:0]     = at;
        d[74:64]   = cnt;
        d[78:75]   = 4'(ty);
        d[79]      = poison;
        d[95:80]   = rid;
        d[103:96]  = tag;
        d[119:104] = cid;
        d[123:121] = tc;
        d[126:124] = attr;
        return d;
    endfunction

    function automatic logic [127:0] ref_hdr(input logic [127:0] d, input logic [7:0] t, input logic [2:0] en);
        int ty;
        bit msg, io, dat, four;
        logic [31:0] w0, w1, w2, w3;
        ty   = int'(d[78:75]);
        msg  = (ty == 12) || (ty == 13);
        io   = (ty == 2) || (ty == 3);
        dat  = (ty == 1) || (ty == 3) || (ty == 13);
        four = msg || (!io && d[63:32] != 32'd0);
        w0 = '0;
        w0[31:29] = {1'b0, dat, four};
        w0[28:24] = msg ? {2'b10, d[114:112]} : (io ? 5'd2 : 5'd0);
        w0[22:20] = d[123:121];
        w0[18]    = d[126] & en[2];
        w0[14]    = d[79];
        w0[13]    = d[125] & en[1];
        w0[12]    = d[124] & en[0];
        if (!msg && !io) w0[11:10] = d[1:0];
        w0[9:0]   = d[73:64];
        w1 = {d[95:80], t, msg ? d[111:104] : {(d[74:64] > 11'd1) ? 4'hF : 4'h0, 4'hF}};
        if (msg) begin
            w2 = d[31:0];
            w3 = d[63:32];
        end else if (four) begin
            w2 = d[63:32];
            w3 = {d[31:2], 2'b00};
        end else begin
            w2 = {d[31:2], 2'b00};
            w3 = '0;
        end
        return {w3, w2, w1, w0};
    endfunction

    task automatic drive_beat(input logic [DW-1:0] d, input logic l);
        bit done;
        done = 0;
        @(negedge clk);
        s_tdata  = d;
        s_tlast  = l;
        s_tvalid = 1'b1;
        while (!done) begin
            #(CLK_P/4);
            if (s_tready) done = 1;
            else @(negedge clk);
        end
    endtask

    task automatic idle;
        @(negedge clk);
        s_tvalid = 1'b0;
    endtask

    task automatic send(input logic [127:0] d, input int npay, input string lbl);
        int ty;
        logic [7:0] t;
        logic [127:0] h;
        ty = int'(d[78:75]);
        if (ty == 1 || ty == 12 || ty == 13 || cfg_client_tag) begin
            t = d[103:96];
        end else begin
            t = gen_model;
            gen_model = gen_model + 8'd1;
        end
        h = ref_hdr(d, t, cfg_attr_en);
        pkt_id++;
        for (int b = 0; b < 2; b++) begin
            exp_q.push_back({(npay == 0 && b == 1), h[b*DW +: DW]});
            hdr_q.push_back(1);
            lbl_q.push_back(lbl);
        end
        for (int k = 0; k < npay; k++) begin
            exp_q.push_back({(k == npay - 1), 32'(pkt_id) ^ 32'hC0DE_0000, 32'(k * 7 + 3)});
            hdr_q.push_back(0);
            lbl_q.push_back("R4");
        end
        drive_beat(d[63:0], 1'b0);
        if (gap_mode) idle();
        drive_beat(d[127:64], npay == 0);
        for (int k = 0; k < npay; k++) begin
            if (gap_mode && k[0]) idle();
            drive_beat({32'(pkt_id) ^ 32'hC0DE_0000, 32'(k * 7 + 3)}, k == npay - 1);
        end
        idle();
    endtask

    task automatic drain;
        int n;
        n = 0;
        while (exp_q.size() > 0 && n < 3000) begin
            @(negedge clk);
            n++;
        end
        if (exp_q.size() > 0) begin
            total++;
            bad++;
            $display("FAIL R5: %0d expected beats never appeared (actual 0 expected %0d)", exp_q.size(), exp_q.size());
            exp_q.delete();
            hdr_q.delete();
            lbl_q.delete();
        end
    endtask

    // Output monitor and reference comparison.
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            m_tready = stall_mode ? (cyc % 3 != 1) : 1'b1;
            #(CLK_P/4);
            if (rst_n) begin
                if (m_tvalid && exp_q.size() > 0 && hdr_q[0]) begin
                    total++;
                    if (s_tready !== 1'b0) begin
                        bad++;
                        $display("FAIL R3: s_tready during header actual %b expected 0", s_tready);
                    end
                end
                if (m_tvalid && m_tready) begin
                    total++;
                    if (exp_q.size() == 0) begin
                        bad++;
                        $display("FAIL R4: unexpected beat actual %h expected none", m_tdata);
                    end else begin
                        logic [DW:0] e;
                        string l;
                        e = exp_q.pop_front();
                        l = lbl_q.pop_front();
                        void'(hdr_q.pop_front());
                        if ({m_tlast, m_tdata} !== e) begin
                            bad++;
                            $display("FAIL %s: beat actual last=%b data=%h expected last=%b data=%h",
                                     l, m_tlast, m_tdata, e[DW], e[DW-1:0]);
                        end
                    end
                end
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: run hung actual running expected done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        // R1: reset values while held
        #1;
        total++;
        if (s_tready !== 1'b1 || m_tvalid !== 1'b0) begin
            bad++;
            $display("FAIL R1: in reset actual tready=%b tvalid=%b expected 1 0", s_tready, m_tvalid);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #(CLK_P/4);
        total++;
        if (s_tready !== 1'b1 || m_tvalid !== 1'b0) begin
            bad++;
            $display("FAIL R1: after reset actual tready=%b tvalid=%b expected 1 0", s_tready, m_tvalid);
        end

        // R6 R7 R10: 3-dword memory read, generator tag
        send(mk_desc(0, 64'h0000_0000_1234_5678, 2'b01, 11'd4, 8'h55, 16'h0, 3'd0, 3'd0, 0, 16'hAB12), 0, "R7");
        // R7 R10: 4-dword memory read
        send(mk_desc(0, 64'h0000_0042_8765_4320, 2'b10, 11'd1, 8'h66, 16'h0, 3'd2, 3'd0, 0, 16'h0101), 0, "R7");
        // R9 R4: posted write with payload
        send(mk_desc(1, 64'h0000_0000_0000_1000, 2'b00, 11'd6, 8'h9A, 16'h0, 3'd0, 3'd0, 0, 16'h0203), 3, "R9");
        // R13 R11: poison, traffic class, address type, all attributes enabled
        send(mk_desc(1, 64'hFFFF_0000_0000_2004, 2'b11, 11'd256, 8'h11, 16'h0, 3'd5, 3'b111, 1, 16'hFE0F), 1, "R13");
        drain();
        cfg_attr_en = 3'b000;
        // R11: all attributes masked
        send(mk_desc(1, 64'h0000_0000_0000_3000, 2'b00, 11'd2, 8'h12, 16'h0, 3'd1, 3'b111, 0, 16'h0001), 1, "R11");
        drain();
        cfg_attr_en = 3'b101;
        send(mk_desc(0, 64'h0000_0000_0000_3100, 2'b00, 11'd0, 8'h13, 16'h0, 3'd0, 3'b111, 0, 16'h0001), 0, "R11");
        drain();
        cfg_attr_en = 3'b111;
        // R8: I/O always 3-dword even with upper bits set
        send(mk_desc(2, 64'h0000_0007_0000_00F0, 2'b11, 11'd1, 8'h21, 16'h0, 3'd0, 3'd0, 0, 16'h0A0B), 0, "R8");
        send(mk_desc(3, 64'h0000_0000_0000_00F4, 2'b00, 11'd1, 8'h22, 16'h0, 3'd0, 3'd0, 0, 16'h0A0B), 1, "R8");
        drain();
        // R10: client tag mode
        cfg_client_tag = 1'b1;
        send(mk_desc(0, 64'h0000_0000_0000_4000, 2'b00, 11'd8, 8'hC3, 16'h0, 3'd0, 3'd0, 0, 16'h0505), 0, "R10");
        drain();
        cfg_client_tag = 1'b0;
        send(mk_desc(0, 64'h0000_0000_0000_4100, 2'b00, 11'd8, 8'hC4, 16'h0, 3'd0, 3'd0, 0, 16'h0505), 0, "R10");
        // R12: messages
        send(mk_desc(12, 64'h1111_2222_3333_4447, 2'b11, 11'd0, 8'h31, {5'h0, 3'b010, 8'h7E}, 3'd0, 3'd0, 0, 16'h0C0D), 0, "R12");
        send(mk_desc(13, 64'h0000_0000_ABCD_0000, 2'b00, 11'd4, 8'h32, {5'h0, 3'b100, 8'h7F}, 3'd3, 3'd0, 0, 16'h0C0D), 2, "R12");
        drain();

        // R5 R2: back-pressure and input gaps
        stall_mode = 1;
        gap_mode   = 1;
        send(mk_desc(1, 64'h0000_0000_0000_5000, 2'b00, 11'd10, 8'h41, 16'h0, 3'd0, 3'd0, 0, 16'h0707), 5, "R5");
        send(mk_desc(0, 64'h0000_0001_0000_5100, 2'b00, 11'd3, 8'h42, 16'h0, 3'd0, 3'd0, 0, 16'h0707), 0, "R2");
        send(mk_desc(13, 64'h0000_0000_0000_0000, 2'b00, 11'd1, 8'h43, {5'h0, 3'b011, 8'h50}, 3'd0, 3'd0, 0, 16'h0707), 1, "R5");
        drain();
        stall_mode = 0;
        gap_mode   = 0;

        // R10: generator wrap from 255 to 0
        for (int i = 0; i < 258; i++) begin
            send(mk_desc(0, 64'h0000_0000_0000_6000 + 64'(i * 4), 2'b00, 11'd1, 8'hEE, 16'h0, 3'd0, 3'd0, 0, 16'h0909), 0, "R10");
        end
        drain();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule